// File: doc/BRIEF.md
# Dual-Mode Toggle Output Timer

An up-counting timer that drives one output level, flipping it every time the count reaches the active compare value. Two data registers hold a "low-phase" and a "high-phase" compare value. The register that feeds the comparator always matches the present output level, so the low and high halves of the output waveform can have different lengths. While the timer is disabled, the output rests at a programmable starting level, and the comparator holds the register that belongs to that level.

A mode bit picks between a one-shot run and a free-running run. In a one-shot run the timer reaches the compare value once, flips the output, raises a timeout pulse and stops with its count cleared. It stays stopped until the enable is dropped and raised again. In a free-running run it wraps to zero and keeps going, and an interrupt-thinning bit can limit the timeout pulse to every second wrap. The count advances only on cycles where the count-clock enable is high. The counter width is a parameter, 8 or 16 bits.

Top module: `toggle_tmr`

## Requirements
- R1: After reset the output is low, the timeout pulse is low, and all configuration fields are zero.
- R2: A write with `cfgAddr`=0 loads the mode fields from data bit 0 (1 = one-shot, 0 = free-running), bit 1 (starting level) and bit 2 (1 = pulse on every second wrap). Address 1 loads the low-phase compare value and address 2 loads the high-phase compare value. A write to address 3 has no effect.
- R3: While `enable` is low, the output equals the starting level one cycle later, the count is zero and no pulse is raised.
- R4: The count advances by one only on an enabled cycle with `tick` high. A timeout happens on a tick cycle where the count equals the compare value, so one phase lasts compare+1 ticks.
- R5: On enabling, the compare value comes from the high-phase register if the starting level is high, and from the low-phase register otherwise. After each flip, it comes from the register that matches the new output level.
- R6: The output flips on every timeout, whatever the interrupt-thinning setting.
- R7: In one-shot mode the timer flips once, pulses once and then stops with the output held. It runs again only after `enable` is dropped and raised.
- R8: In free-running mode the count wraps to zero at each timeout and the run repeats indefinitely.
- R9: In free-running mode with thinning off, every timeout pulses. With thinning on, only every second timeout pulses, and the first pulse comes on the second timeout after enabling.
- R10: `timeoutIrq` is a one-cycle pulse that appears in the same cycle as the output flip it reports.
- R11: With a 16-bit counter, compare values above 255 set the phase length exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select |
| cfgData | input | CNT_W | Configuration write data |
| enable | input | 1 | Run enable; low holds the timer idle |
| tick | input | 1 | Count-clock enable |
| timerOut | output | 1 | Toggling timer output level |
| timeoutIrq | output | 1 | Timeout interrupt pulse |

## Verification
Directed runs use unequal low and high compare values with a steady tick. They measure the first timeout edge and the length of each phase, which separates a wrong comparator source from an off-by-one in the wrap. The same run is repeated with interrupt thinning on, and then in one-shot mode with a high starting level, to tell the pulse divider and the stop-and-restart behaviour apart from the output flipping. Separate cases cover a tick held low, a write to the unused address and a 300-count phase. A long random phase then changes configuration, enable and tick, and compares the output and the pulse every cycle against a bench model.

// File: rtl/toggle_tmr_pkg.sv
package toggle_tmr_pkg;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;

  localparam int MODE_BIT_ONESHOT = 0;
  localparam int MODE_BIT_START   = 1;
  localparam int MODE_BIT_THIN    = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;  // idle: zero count, load start level and compare
    logic step;   // advance count
    logic wrap;   // timeout: zero count, flip level, reload compare
  } tmrStrobe_t;

endpackage

// File: rtl/toggle_tmr_regs.sv
module toggle_tmr_regs
  import toggle_tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  output logic             oneShot,
  output logic             startLevel,
  output logic             thinIrq,
  output logic [CNT_W-1:0] lowVal,
  output logic [CNT_W-1:0] highVal
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oneShot    <= 1'b0;
      startLevel <= 1'b0;
      thinIrq    <= 1'b0;
      lowVal     <= '0;
      highVal    <= '0;
    end else if (cfgWe) begin
      unique case (cfgAddr)
        ADDR_MODE: begin
          oneShot    <= cfgData[MODE_BIT_ONESHOT];
          startLevel <= cfgData[MODE_BIT_START];
          thinIrq    <= cfgData[MODE_BIT_THIN];
        end
        ADDR_LOW:  lowVal  <= cfgData;
        ADDR_HIGH: highVal <= cfgData;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/toggle_tmr_dp.sv
module toggle_tmr_dp
  import toggle_tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic             startLevel,
  input  logic [CNT_W-1:0] lowVal,
  input  logic [CNT_W-1:0] highVal,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic             outLevel,
  output logic             match
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] startCmp;
  logic [CNT_W-1:0] nextCmp;

  // compare source follows the level the output is about to hold
  assign startCmp = startLevel ? highVal : lowVal;
  assign nextCmp  = outLevel   ? lowVal  : highVal;
  assign match    = (cntVal == cmpVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal   <= '0;
      cmpVal   <= '0;
      outLevel <= 1'b0;
    end else if (strobe.clear) begin
      cntVal   <= '0;
      cmpVal   <= startCmp;
      outLevel <= startLevel;
    end else if (strobe.wrap) begin
      cntVal   <= '0;
      cmpVal   <= nextCmp;
      outLevel <= ~outLevel;
    end else if (strobe.step) begin
      cntVal   <= cntVal + CNT_ONE;
    end
  end

endmodule

// File: rtl/toggle_tmr_ctrl.sv
module toggle_tmr_ctrl
  import toggle_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic       match,
  input  logic       oneShot,
  input  logic       thinIrq,
  output tmrStrobe_t strobe,
  output logic       stopDone,
  output logic       timeoutIrq
);

  logic active;
  logic halfFlag;
  logic irqNext;

  assign active       = enable && !stopDone;
  assign strobe.clear = !enable;
  assign strobe.wrap  = active && tick && match;
  assign strobe.step  = active && tick && !match;

  assign irqNext = strobe.wrap && (oneShot || !thinIrq || halfFlag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopDone   <= 1'b0;
      halfFlag   <= 1'b0;
      timeoutIrq <= 1'b0;
    end else begin
      timeoutIrq <= irqNext;
      if (!enable) begin
        stopDone <= 1'b0;
        halfFlag <= 1'b0;
      end else if (strobe.wrap) begin
        if (oneShot) stopDone <= 1'b1;
        else         halfFlag <= ~halfFlag;
      end
    end
  end

endmodule

// File: rtl/toggle_tmr.sv
module toggle_tmr
  import toggle_tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [1:0]       cfgAddr,
  input  logic [CNT_W-1:0] cfgData,
  input  logic             enable,
  input  logic             tick,
  output logic             timerOut,
  output logic             timeoutIrq
);

  logic             oneShot;
  logic             startLevel;
  logic             thinIrq;
  logic [CNT_W-1:0] lowVal;
  logic [CNT_W-1:0] highVal;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  logic             match;
  logic             stopDone;
  tmrStrobe_t       strobe;

  toggle_tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .oneShot(oneShot), .startLevel(startLevel), .thinIrq(thinIrq),
    .lowVal(lowVal), .highVal(highVal)
  );

  toggle_tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick), .match(match),
    .oneShot(oneShot), .thinIrq(thinIrq), .strobe(strobe),
    .stopDone(stopDone), .timeoutIrq(timeoutIrq)
  );

  toggle_tmr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startLevel(startLevel),
    .lowVal(lowVal), .highVal(highVal), .cntVal(cntVal), .cmpVal(cmpVal),
    .outLevel(timerOut), .match(match)
  );

endmodule

// File: rtl/toggle_tmr_chk.sv
module toggle_tmr_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             tick,
  input logic             timerOut,
  input logic             timeoutIrq,
  input logic             startLevel,
  input logic             stopDone,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] cmpVal
);

  AST_IRQ_WITH_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> (timerOut != $past(timerOut))); // R10

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (timerOut == $past(startLevel)) && !timeoutIrq && (cntVal == '0)); // R3

  AST_FLIP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && (timerOut != $past(timerOut))) |-> $past(tick)); // R4

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !tick) |=> $stable(cntVal)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (cntVal <= cmpVal)); // R4

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stopDone && enable) |=> $stable(timerOut) && !timeoutIrq); // R7

endmodule

bind toggle_tmr toggle_tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
  .timerOut(timerOut), .timeoutIrq(timeoutIrq), .startLevel(startLevel),
  .stopDone(stopDone), .cntVal(cntVal), .cmpVal(cmpVal)
);

// File: tb/test_toggle_tmr.sv
module test_toggle_tmr;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int WATCHDOG_CYC = 100000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgAddr = '0;
  logic [CW-1:0] cfgData = '0;
  logic          enable = 1'b0;
  logic          tick = 1'b0;
  logic          timerOut;
  logic          timeoutIrq;

  int nChecks = 0;
  int nFails = 0;
  int irqSeen = 0;
  int flips = 0;
  logic prevOut = 1'b0;
  bit finished = 0;

  // bench model state
  logic          mOneShot, mStart, mThin, mOut, mIrq, mDone, mHalf;
  logic [CW-1:0] mLow, mHigh, mCnt, mCmp;

  toggle_tmr #(.CNT_W(CW)) i_toggle_tmr (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .enable(enable), .tick(tick), .timerOut(timerOut), .timeoutIrq(timeoutIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] pickCmp(input logic lvl, input logic [CW-1:0] lo,
                                            input logic [CW-1:0] hi);
    return lvl ? hi : lo;
  endfunction

  // model: next state from the requirements
  always @(posedge clk) begin
    logic wrap;
    if (!rstN) begin
      mOneShot = 0; mStart = 0; mThin = 0; mLow = '0; mHigh = '0;
      mCnt = '0; mCmp = '0; mOut = 0; mIrq = 0; mDone = 0; mHalf = 0;
    end else begin
      wrap = enable && !mDone && tick && (mCnt == mCmp);
      mIrq = wrap && (mOneShot || !mThin || mHalf);
      if (!enable) begin
        mCnt = '0; mCmp = pickCmp(mStart, mLow, mHigh); mOut = mStart;
        mDone = 0; mHalf = 0;
      end else if (wrap) begin
        mCnt = '0; mOut = !mOut; mCmp = pickCmp(mOut, mLow, mHigh);
        if (mOneShot) mDone = 1; else mHalf = !mHalf;
      end else if (enable && !mDone && tick) begin
        mCnt = mCnt + 1'b1;
      end
      if (cfgWe) begin
        case (cfgAddr)
          2'd0: begin mOneShot = cfgData[0]; mStart = cfgData[1]; mThin = cfgData[2]; end
          2'd1: mLow = cfgData;
          2'd2: mHigh = cfgData;
          default: ;
        endcase
      end
    end
  end

  // per-cycle compare and event counting, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(timerOut === mOut, "R6 output level vs model", int'(timerOut), int'(mOut));
      chk(timeoutIrq === mIrq, "R9 pulse vs model", int'(timeoutIrq), int'(mIrq));
      if (timeoutIrq) irqSeen++;
      if (timerOut !== prevOut) flips++;
    end
    prevOut = timerOut;
  end

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #4;
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    run(1);
    cfgWe = 1'b0;
  endtask

  task automatic clearCounts();
    irqSeen = 0; flips = 0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYC, 0);
    finishRun();
  end

  initial begin
    run(3);
    settle();
    chk(timerOut == 1'b0, "R1 output after reset", int'(timerOut), 0);
    chk(timeoutIrq == 1'b0, "R1 pulse after reset", int'(timeoutIrq), 0);
    rstN = 1'b1;
    run(1);

    // free-running, start low, low=3 high=5
    wr(2'd1, 16'd3);
    wr(2'd2, 16'd5);
    wr(2'd0, 16'd0);
    run(2); settle();
    chk(timerOut == 1'b0, "R3 idle at start level low", int'(timerOut), 0);
    clearCounts();
    enable = 1'b1; tick = 1'b1;
    run(3); settle();
    chk(irqSeen == 0, "R4 no timeout before compare+1 ticks", irqSeen, 0);
    run(1); settle();
    chk(irqSeen == 1, "R10 pulse on 4th tick", irqSeen, 1);
    chk(timerOut == 1'b1, "R5 first phase uses low register", int'(timerOut), 1);
    run(36); settle();
    chk(irqSeen == 8, "R8 repeated timeouts over 40 ticks", irqSeen, 8);
    chk(flips == 8, "R6 flips over 40 ticks", flips, 8);
    run(3); settle();
    chk(timerOut == 1'b0, "R5 low phase still running", int'(timerOut), 0);
    run(1); settle();
    chk(timerOut == 1'b1, "R5 low phase is 4 ticks", int'(timerOut), 1);
    run(5); settle();
    chk(timerOut == 1'b1, "R5 high phase still running", int'(timerOut), 1);
    run(1); settle();
    chk(timerOut == 1'b0, "R5 high phase is 6 ticks", int'(timerOut), 0);

    // thinning on
    enable = 1'b0;
    wr(2'd0, 16'b100);
    run(1); settle();
    chk(timerOut == 1'b0, "R3 back to start level", int'(timerOut), 0);
    clearCounts();
    enable = 1'b1;
    run(4); settle();
    chk(irqSeen == 0 && flips == 1, "R9 first timeout silent", irqSeen, 0);
    run(6); settle();
    chk(irqSeen == 1, "R9 second timeout pulses", irqSeen, 1);
    run(30); settle();
    chk(irqSeen == 4, "R9 every second timeout", irqSeen, 4);
    chk(flips == 8, "R6 flips with thinning on", flips, 8);

    // one-shot, start high
    enable = 1'b0;
    wr(2'd0, 16'b011);
    run(1); settle();
    chk(timerOut == 1'b1, "R3 idle at start level high", int'(timerOut), 1);
    clearCounts();
    enable = 1'b1;
    run(5); settle();
    chk(flips == 0, "R5 start high uses high register", flips, 0);
    run(1); settle();
    chk(flips == 1 && irqSeen == 1, "R7 one flip one pulse", flips, 1);
    run(30); settle();
    chk(flips == 1, "R7 stopped after one-shot", flips, 1);
    chk(irqSeen == 1, "R7 no further pulse", irqSeen, 1);
    chk(timerOut == 1'b0, "R7 output held", int'(timerOut), 0);
    enable = 1'b0;
    run(2); settle();
    clearCounts();
    enable = 1'b1;
    run(6); settle();
    chk(flips == 1, "R7 re-armed by enable", flips, 1);

    // tick low holds count
    enable = 1'b0;
    wr(2'd0, 16'd0);
    run(1); settle();
    clearCounts();
    enable = 1'b1; tick = 1'b0;
    run(20); settle();
    chk(flips == 0, "R4 no progress without tick", flips, 0);
    tick = 1'b1;
    run(4); settle();
    chk(flips == 1, "R4 resumes with tick", flips, 1);

    // address 3 ignored
    enable = 1'b0;
    wr(2'd3, 16'd0);
    run(1); settle();
    clearCounts();
    enable = 1'b1;
    run(1); settle();
    chk(flips == 0, "R2 addr 3 write ignored", flips, 0);
    run(3); settle();
    chk(flips == 1, "R2 low register intact", flips, 1);

    // 16-bit compare
    enable = 1'b0;
    wr(2'd1, 16'd300);
    run(1); settle();
    clearCounts();
    enable = 1'b1;
    run(300); settle();
    chk(flips == 0, "R11 no timeout before 301 ticks", flips, 0);
    run(1); settle();
    chk(flips == 1, "R11 timeout at 301 ticks", flips, 1);

    // constrained random
    begin
      int seed;
      seed = $urandom(32'h5eed_7a11);
      for (int i = 0; i < 4000; i++) begin
        if (($urandom % 40) == 0) enable = ~enable;
        tick = (($urandom % 10) < 7);
        if ((!enable && ($urandom % 3) == 0) || ($urandom % 50) == 0) begin
          cfgWe = 1'b1;
          cfgAddr = 2'($urandom % 4);
          cfgData = CW'($urandom % 13);
        end else begin
          cfgWe = 1'b0;
        end
        run(1);
      end
      cfgWe = 1'b0;
      run(2);
    end

    finishRun();
  end

endmodule